// File: doc/BRIEF.md
# Micro-Order Operate Datapath

This block carries out one operate instruction of an 18-bit ones'-complement machine. The instruction word does not hold an opcode. Each of its bits switches on one micro-order, and each micro-order acts on four registers: the accumulator (AC), the memory buffer (MBR), the live register (LR) and a 14-bit index register (XR). The enabled micro-orders fire in four fixed time steps, one clock each. This lets a single word combine a clear, transfers, a logical merge, a full ones'-complement add and a right shift in a defined order.

Bit 0 is the most significant bit of every word. The surrounding machine places memory data into MBR through a write port while the block is idle. It then issues an instruction with a one-cycle start strobe and waits for the done pulse. Two build-time parameters choose the variants that share an instruction bit. One picks rotate or arithmetic shift. The other picks OR or AND as the merge of LR into MBR.

Top module: `opr_datapath`

## Requirements
- R1: After reset, AC, MBR, LR and XR are zero, and busy and done are low.
- R2: A start strobe is accepted only while the block is idle and both word bits 0 and 1 are one. Any other word has no effect: busy and done stay low and no register changes.
- R3: When a start is accepted at edge E0, busy is high for the four following cycles, one per step. Done is high for exactly one cycle after edge E4, busy is low in that cycle, and the final register values are visible in it.
- R4: Step 1. Bit 2 clears AC. Bit 3 copies the AC value from before the clear into MBR. Bit 9 copies XR into MBR, placing the XR sign in MBR bits 0–4 and XR bits 5–17 in MBR bits 5–17. When bits 3 and 9 are both set, MBR receives the OR of the two sources.
- R5: Step 2. Bit 14 complements AC. Bit 11 copies LR into MBR and bit 10 copies MBR into LR. When both are set, LR and MBR exchange contents.
- R6: Step 2. Bit 17 merges LR into MBR: an OR when LOGIC_OR=1 and an AND when LOGIC_OR=0. When bit 17 is set, MBR takes the merge result and bit 11 does not write MBR.
- R7: Step 3. Bit 15 XORs MBR into AC. Bit 12 loads XR with MBR bit 0 as its sign and MBR bits 5–17 as its bits 5–17. XR changes at no other time.
- R8: Step 4. Bit 16 adds the carry digits into AC, which gives AC = (AC xor MBR) plus MBR in ones' complement with end-around carry. Bits 15 and 16 together therefore form the ones'-complement sum of the AC and MBR values present before step 3.
- R9: Step 4. Bit 13 shifts AC right by one, after the carry step of that same step. With ROTATE=1, bit 17 moves to bit 0. With ROTATE=0, bit 0 is kept and bit 17 is lost.
- R10: Word bits 4 through 8 have no effect on any register.
- R11: A write strobe loads MBR only while the block is idle. A write strobe raised while busy is ignored.
- R12: A start strobe raised while busy is ignored and does not start a second instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe that offers an instruction |
| instr | input | 18 | Operate instruction word, bit 0 most significant |
| mbr_wr | input | 1 | MBR write strobe from the memory side |
| mbr_wdata | input | 18 | Data for the MBR write |
| ac | output | 18 | Accumulator |
| mbr | output | 18 | Memory buffer register |
| lr | output | 18 | Live register |
| xr | output | 14 | Index register, bit 4 is its sign |
| busy | output | 1 | High while steps 1 to 4 run |
| done | output | 1 | One-cycle pulse after step 4 |

## Verification
In step 4, the carry add and the right shift both update AC in the same clock. The shift must act on the result of the carry, not on the value from step 3. The bench sweeps every combination of the micro-order bits and the clear and transfer bits, with random register contents, so it often sets both bit 16 and bit 13 together. The result is judged against an integer end-around-carry sum that is then shifted. This is done for both parameter variants, on two instances fed the same stimulus. The other shared clock is step 2, where the merge, the LR-to-MBR transfer and the exchange meet. The same sweep covers it.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int WORD_W = 18;
  localparam int XR_W   = 14;
  localparam int XR_LO  = WORD_W - XR_W;
  localparam int FILL_W = XR_LO + 1;
  localparam int NSTEP  = 4;

  typedef logic [0:WORD_W-1]     word_t;
  typedef logic [XR_LO:WORD_W-1] xr_t;

  // instruction bit positions (bit 0 is the most significant)
  localparam int B_OPA = 0;
  localparam int B_OPB = 1;
  localparam int B_CLA = 2;
  localparam int B_AMB = 3;
  localparam int B_XMB = 9;
  localparam int B_MBL = 10;
  localparam int B_LMB = 11;
  localparam int B_MBX = 12;
  localparam int B_SHF = 13;
  localparam int B_COM = 14;
  localparam int B_PAD = 15;
  localparam int B_CRY = 16;
  localparam int B_LGC = 17;

  typedef struct packed {
    logic cla;
    logic amb;
    logic xmb;
    logic mbl;
    logic lmb;
    logic mbx;
    logic shf;
    logic com;
    logic pad;
    logic cry;
    logic lgc;
  } ctl_t;

  function automatic word_t ones_add(input word_t a, input word_t b);
    logic [WORD_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return word_t'(s[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, s[WORD_W]});
  endfunction

  // carry digits of a partially added AC: restores the full sum
  function automatic word_t carry_fold(input word_t acc, input word_t m);
    return ones_add(acc ^ m, m);
  endfunction

  function automatic word_t rot_right(input word_t w);
    return {w[WORD_W-1], w[0:WORD_W-2]};
  endfunction

  function automatic word_t ash_right(input word_t w);
    return {w[0], w[0:WORD_W-2]};
  endfunction

  function automatic word_t xr_widen(input xr_t x);
    return {{FILL_W{x[XR_LO]}}, x[XR_LO+1:WORD_W-1]};
  endfunction

  function automatic xr_t xr_narrow(input word_t m);
    return {m[0], m[XR_LO+1:WORD_W-1]};
  endfunction
endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  word_t w,
  output logic  is_op,
  output ctl_t  ctl
);
  always_comb begin
    is_op   = w[B_OPA] & w[B_OPB];
    ctl.cla = w[B_CLA];
    ctl.amb = w[B_AMB];
    ctl.xmb = w[B_XMB];
    ctl.mbl = w[B_MBL];
    ctl.lmb = w[B_LMB];
    ctl.mbx = w[B_MBX];
    ctl.shf = w[B_SHF];
    ctl.com = w[B_COM];
    ctl.pad = w[B_PAD];
    ctl.cry = w[B_CRY];
    ctl.lgc = w[B_LGC];
  end
endmodule

// File: rtl/opr_seq.sv
module opr_seq
  import opr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  output logic [NSTEP-1:0] stp,
  output logic             busy,
  output logic             done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stp  <= '0;
      done <= 1'b0;
    end else begin
      stp  <= {stp[NSTEP-2:0], accept};
      done <= stp[NSTEP-1];
    end
  end

  assign busy = |stp;

  assert_step_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stp));
  assert_accept_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> stp[0]);
  assert_done_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stp[NSTEP-1] |=> done && !busy);
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/opr_acc.sv
module opr_acc
  import opr_pkg::*;
#(
  parameter bit ROTATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTEP-1:0] stp,
  input  ctl_t             ctl,
  input  word_t            mbr,
  output word_t            ac
);
  word_t carried, shifted, step4_val;

  assign carried = ctl.cry ? carry_fold(ac, mbr) : ac;

  generate
    if (ROTATE) begin : g_rot
      assign shifted = rot_right(carried);
    end else begin : g_ash
      assign shifted = ash_right(carried);
    end
  endgenerate

  assign step4_val = ctl.shf ? shifted : carried;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ac <= '0;
    else if (stp[0] && ctl.cla)
      ac <= '0;
    else if (stp[1] && ctl.com)
      ac <= ~ac;
    else if (stp[2] && ctl.pad)
      ac <= ac ^ mbr;
    else if (stp[3] && (ctl.cry || ctl.shf))
      ac <= step4_val;
  end

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stp[0] && ctl.cla |=> ac == '0);
  assert_complement_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stp[1] && ctl.com |=> ac == ~$past(ac));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stp == '0 |=> $stable(ac));
endmodule

// File: rtl/opr_xfer.sv
module opr_xfer
  import opr_pkg::*;
#(
  parameter bit LOGIC_OR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTEP-1:0] stp,
  input  ctl_t             ctl,
  input  logic             busy,
  input  word_t            ac,
  input  logic             mbr_wr,
  input  word_t            mbr_wdata,
  output word_t            mbr,
  output word_t            lr,
  output xr_t              xr
);
  word_t merged, step1_val;
  logic  load_ok;

  generate
    if (LOGIC_OR) begin : g_or
      assign merged = lr | mbr;
    end else begin : g_and
      assign merged = lr & mbr;
    end
  endgenerate

  assign step1_val = (ctl.amb ? ac : '0) | (ctl.xmb ? xr_widen(xr) : '0);
  assign load_ok   = mbr_wr && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)
      mbr <= '0;
    else if (load_ok)
      mbr <= mbr_wdata;
    else if (stp[0] && (ctl.amb || ctl.xmb))
      mbr <= step1_val;
    else if (stp[1] && ctl.lgc)
      mbr <= merged;
    else if (stp[1] && ctl.lmb)
      mbr <= lr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      lr <= '0;
    else if (stp[1] && ctl.mbl)
      lr <= mbr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      xr <= '0;
    else if (stp[2] && ctl.mbx)
      xr <= xr_narrow(mbr);
  end

  assert_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stp[1] && ctl.lmb && ctl.mbl && !ctl.lgc |=> mbr == $past(lr) && lr == $past(mbr));
  assert_xr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(stp[2] && ctl.mbx) |=> $stable(xr));
  assert_busy_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(stp[0] && (ctl.amb || ctl.xmb)) && !(stp[1] && (ctl.lgc || ctl.lmb))
    |=> $stable(mbr));
endmodule

// File: rtl/opr_datapath.sv
module opr_datapath
  import opr_pkg::*;
#(
  parameter bit ROTATE   = 1'b1,
  parameter bit LOGIC_OR = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  word_t instr,
  input  logic  mbr_wr,
  input  word_t mbr_wdata,
  output word_t ac,
  output word_t mbr,
  output word_t lr,
  output xr_t   xr,
  output logic  busy,
  output logic  done
);
  logic             is_op, accept;
  ctl_t             ctl_in, ctl_q;
  logic [NSTEP-1:0] stp;

  opr_decode u_decode (
    .w     (instr),
    .is_op (is_op),
    .ctl   (ctl_in)
  );

  assign accept = start && is_op && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctl_q <= '0;
    else if (accept)
      ctl_q <= ctl_in;
  end

  opr_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .stp    (stp),
    .busy   (busy),
    .done   (done)
  );

  opr_acc #(.ROTATE(ROTATE)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .stp   (stp),
    .ctl   (ctl_q),
    .mbr   (mbr),
    .ac    (ac)
  );

  opr_xfer #(.LOGIC_OR(LOGIC_OR)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .stp       (stp),
    .ctl       (ctl_q),
    .busy      (busy),
    .ac        (ac),
    .mbr_wr    (mbr_wr),
    .mbr_wdata (mbr_wdata),
    .mbr       (mbr),
    .lr        (lr),
    .xr        (xr)
  );

  assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !is_op && !busy |=> !busy);
  assert_ignore_busy_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !stp[NSTEP-1] |=> $stable(ctl_q));
endmodule

// File: tb/test_opr_datapath.sv
module test_opr_datapath;
  localparam logic [17:0] OPB = 18'h30000;
  localparam logic [17:0] CLA = 18'h1 << 15;
  localparam logic [17:0] AMB = 18'h1 << 14;
  localparam logic [17:0] XMB = 18'h1 << 8;
  localparam logic [17:0] MBL = 18'h1 << 7;
  localparam logic [17:0] LMB = 18'h1 << 6;
  localparam logic [17:0] MBX = 18'h1 << 5;
  localparam logic [17:0] SHF = 18'h1 << 4;
  localparam logic [17:0] COM = 18'h1 << 3;
  localparam logic [17:0] PAD = 18'h1 << 2;
  localparam logic [17:0] CRY = 18'h1 << 1;
  localparam logic [17:0] LGC = 18'h1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mbr_wr = 1'b0;
  logic [17:0] instr = '0, mbr_wdata = '0;
  logic [17:0] ac_a, mbr_a, lr_a, ac_b, mbr_b, lr_b;
  logic [13:0] xr_a, xr_b;
  logic busy_a, done_a, busy_b, done_b;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] rng = 32'h1234_5678;
  logic [17:0] e_ac [2], e_mbr [2], e_lr [2];
  logic [13:0] e_xr [2];
  bit t_ok;

  always #5 clk = ~clk;

  opr_datapath #(.ROTATE(1'b1), .LOGIC_OR(1'b1)) i_opr_datapath (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .mbr_wr(mbr_wr),
    .mbr_wdata(mbr_wdata), .ac(ac_a), .mbr(mbr_a), .lr(lr_a), .xr(xr_a),
    .busy(busy_a), .done(done_a));

  opr_datapath #(.ROTATE(1'b0), .LOGIC_OR(1'b0)) i_opr_datapath_alt (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .mbr_wr(mbr_wr),
    .mbr_wdata(mbr_wdata), .ac(ac_b), .mbr(mbr_b), .lr(lr_b), .xr(xr_b),
    .busy(busy_b), .done(done_b));

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng[17:0];
  endfunction

  // independent model of one operate word; rot/lor select the variants
  task automatic model(input bit rot, input bit lor, input logic [17:0] w,
                       inout logic [17:0] ac, inout logic [17:0] mbr,
                       inout logic [17:0] lr, inout logic [13:0] xr);
    logic [17:0] xe, m0, l0;
    int s;
    xe = {{5{xr[13]}}, xr[12:0]};
    if (w[14] || w[8]) mbr = (w[14] ? ac : 18'h0) | (w[8] ? xe : 18'h0);
    if (w[15]) ac = '0;
    m0 = mbr;
    l0 = lr;
    if (w[3]) ac = ~ac;
    if (w[0]) mbr = lor ? (l0 | m0) : (l0 & m0);
    else if (w[6]) mbr = l0;
    if (w[7]) lr = m0;
    if (w[2]) ac = ac ^ mbr;
    if (w[5]) xr = {mbr[17], mbr[12:0]};
    if (w[1]) begin
      s = int'(ac ^ mbr) + int'(mbr);
      if (s > 262143) s = s - 262143;
      ac = s[17:0];
    end
    if (w[4]) ac = rot ? {ac[0], ac[17:1]} : {ac[17], ac[17:1]};
  endtask

  task automatic load(input logic [17:0] v);
    @(negedge clk);
    mbr_wr = 1'b1;
    mbr_wdata = v;
    @(negedge clk);
    mbr_wr = 1'b0;
  endtask

  // issues a word and waits until the done cycle; t_ok records R3 timing
  task automatic run_op(input logic [17:0] w);
    @(negedge clk);
    start = 1'b1;
    instr = w;
    @(negedge clk);
    start = 1'b0;
    t_ok = busy_a && busy_b && !done_a;
    repeat (3) begin
      @(negedge clk);
      t_ok = t_ok && busy_a && busy_b && !done_a && !done_b;
    end
    @(negedge clk);
    t_ok = t_ok && done_a && done_b && !busy_a && !busy_b;
  endtask

  task automatic setup(input logic [17:0] av, input logic [17:0] mv,
                       input logic [17:0] lv, input logic [17:0] xv);
    load(lv);
    run_op(OPB | MBL);
    load(xv);
    run_op(OPB | MBX);
    load(av);
    run_op(OPB | CLA | PAD);
    load(mv);
    for (int k = 0; k < 2; k++) begin
      e_ac[k] = av;
      e_mbr[k] = mv;
      e_lr[k] = lv;
      e_xr[k] = {xv[17], xv[12:0]};
    end
  endtask

  task automatic compare(input string pfx);
    check({pfx, " R8 ac"}, ac_a, e_ac[0]);
    check({pfx, " R6 mbr"}, mbr_a, e_mbr[0]);
    check({pfx, " R5 lr"}, lr_a, e_lr[0]);
    check({pfx, " R7 xr"}, {4'h0, xr_a}, {4'h0, e_xr[0]});
    check({pfx, " R9 alt ac"}, ac_b, e_ac[1]);
    check({pfx, " R6 alt mbr"}, mbr_b, e_mbr[1]);
    check({pfx, " R5 alt lr"}, lr_b, e_lr[1]);
    check({pfx, " R7 alt xr"}, {4'h0, xr_b}, {4'h0, e_xr[1]});
  endtask

  task automatic exec_model(input logic [17:0] w);
    model(1'b1, 1'b1, w, e_ac[0], e_mbr[0], e_lr[0], e_xr[0]);
    model(1'b0, 1'b0, w, e_ac[1], e_mbr[1], e_lr[1], e_xr[1]);
    run_op(w);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R3 actual %0d expected below 190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [17:0] w;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ac", ac_a, 18'h0);
    check("R1 mbr", mbr_a, 18'h0);
    check("R1 lr", lr_a, 18'h0);
    check("R1 xr", {4'h0, xr_a}, 18'h0);
    check("R1 busy/done", {16'h0, busy_a, done_a}, 18'h0);

    // R3 step timing and single done pulse
    setup(18'h0_0005, 18'h3_fffa, 18'h0, 18'h0);
    exec_model(OPB | PAD | CRY);
    check("R3 timing", {17'h0, t_ok}, 18'h1);
    compare("R8 end-around");
    @(negedge clk);
    check("R3 done single", {17'h0, done_a}, 18'h0);

    // R8 sum of a value and its complement gives minus zero
    setup(18'h0_1234, ~18'h0_1234, 18'h0, 18'h0);
    exec_model(OPB | PAD | CRY);
    check("R8 minus zero", ac_a, 18'h3_ffff);

    // R4 sign extension of a negative index into MBR
    setup(18'h0, 18'h0, 18'h0, 18'h2_0007);
    exec_model(OPB | XMB);
    check("R4 sign fill", mbr_a, 18'h3_e007);

    // R9 carry then shift in the same step
    setup(18'h2_0001, 18'h0_0001, 18'h0, 18'h0);
    exec_model(OPB | PAD | CRY | SHF);
    compare("R9 carry+shift");

    // R2 non-operate word: bit 0 clear
    setup(18'h0_00ff, 18'h0_0f0f, 18'h1_1111, 18'h0_0042);
    @(negedge clk);
    start = 1'b1;
    instr = 18'h1_0000 | CLA | COM | LMB;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    repeat (6) begin
      @(negedge clk);
      seen = seen | busy_a | done_a | busy_b | done_b;
    end
    check("R2 no activity", {17'h0, seen}, 18'h0);
    compare("R2 unchanged");

    // R12 and R11: start and MBR write while busy are ignored
    @(negedge clk);
    start = 1'b1;
    instr = OPB | MBL;
    @(negedge clk);
    start = 1'b1;
    instr = OPB | CLA | COM;
    mbr_wr = 1'b1;
    mbr_wdata = 18'h2_aaaa;
    @(negedge clk);
    start = 1'b0;
    mbr_wr = 1'b0;
    seen = 1'b0;
    repeat (8) begin
      @(negedge clk);
      seen = seen | (busy_a & done_a);
    end
    for (int k = 0; k < 2; k++) model(k == 0, k == 0, OPB | MBL, e_ac[k], e_mbr[k], e_lr[k], e_xr[k]);
    check("R12 ac kept", ac_a, 18'h0_00ff);
    check("R11 mbr kept", mbr_a, 18'h0_0f0f);
    compare("R12 single op");

    // R4 R5 R6 R7 R8 R9 R10: sweep all micro-order and step-1 bits
    for (int c = 0; c < 2048; c++) begin
      logic [17:0] av, mv, lv, xv;
      av = next_rand();
      mv = (c[1:0] == 2'b11) ? ~av : next_rand();
      lv = next_rand();
      xv = next_rand();
      setup(av, mv, lv, xv);
      w = OPB | (18'(c[10:9]) << 14) | 18'(c[8:0]) | (18'(next_rand() & 18'h1f) << 9);
      exec_model(w);
      compare("sweep R10");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule